// File: doc/BRIEF.md
# Transient Versus Permanent Fault Classifier

This block watches over a single functional unit after a runtime check has judged one of its results. A start strobe arrives together with the outcome of that first check. If the check passed, nothing happens. If it failed, the block asks for the unit to be run again through a request/done handshake. Each completed rerun returns a result word and a pass/fail flag from the check.

A failing second run means a permanent fault. A passing second run has its word held in a register, and a third run follows. The fault is judged transient, and the unit is kept, only when the third run passes and its word equals the held second word. In every other case the fault is judged permanent and a replacement should start. A rerun that does not finish within a set number of cycles counts as a failed run.

Each verdict is a pulse one cycle long, after which the block goes back to idle. A sticky flag records that this unit has had a permanent fault, and only reset clears it.

The controller has five states. IDLE waits for a start. SECOND is the first rerun and THIRD the second rerun; the request is high in both. KEEP issues the transient pulse and REPLACE issues the permanent pulse. Transitions:

- IDLE to SECOND on a start with a failed check.
- SECOND to REPLACE on a failed done or on a timeout.
- SECOND to THIRD on a passing done, which also loads the held word.
- THIRD to KEEP on a passing done whose word matches.
- THIRD to REPLACE on a mismatch, a failed done or a timeout.
- KEEP and REPLACE to IDLE unconditionally.

Top module: `fault_verdict_unit`

## Requirements
- R1: A start with `first_ok_i`=1 is ignored: in the next cycle `busy_o`, `rerun_req_o`, `transient_o` and `permanent_o` are all 0.
- R2: A start with `first_ok_i`=0 while idle drives `rerun_req_o` and `busy_o` to 1 from the next cycle.
- R3: If the first rerun completes (`rerun_done_i`=1) with `rerun_ok_i`=0, `permanent_o` is 1 in the cycle after the done.
- R4: If the first rerun completes with `rerun_ok_i`=1, `rerun_req_o` stays 1 to request a third run, and the word is held for comparison.
- R5: If the third run completes with `rerun_ok_i`=1 and a word equal to the held second word, `transient_o` is 1 in the cycle after the done, and `permanent_o` stays 0.
- R6: If the third run completes with a word different from the held word, or with `rerun_ok_i`=0, `permanent_o` is 1 in the cycle after the done.
- R7: A rerun whose done has not arrived after TIMEOUT_CYC cycles of request counts as a failure: with the request first seen high in cycle 0, `permanent_o` is 1 in cycle TIMEOUT_CYC, and it is 0 with the request still high in cycle TIMEOUT_CYC-1. This applies to both reruns.
- R8: Each verdict pulse lasts one cycle, after which `busy_o` is 0. The two verdicts are never high together. A start strobe while busy is ignored and does not restart the sequence.
- R9: `perm_latched_o` is 0 after reset. It becomes 1 in the cycle after a permanent verdict and keeps that value until reset, even across later transient verdicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Strobe: a first check outcome is available |
| first_ok_i | input | 1 | Outcome of the first check (1 = passed) |
| rerun_req_o | output | 1 | Request to run the unit again, held until done |
| rerun_done_i | input | 1 | Rerun finished; word and outcome valid |
| rerun_ok_i | input | 1 | Outcome of the check on the rerun (1 = passed) |
| rerun_word_i | input | WORD_W | Result word of the rerun |
| busy_o | output | 1 | Classification in progress |
| transient_o | output | 1 | One-cycle pulse: transient fault, keep the unit |
| permanent_o | output | 1 | One-cycle pulse: permanent fault, replace the unit |
| perm_latched_o | output | 1 | Sticky record of a permanent verdict |

## Verification
The bench drives several rerun patterns, and each one tells the two verdicts apart on a different ground:

- A passing first check shows that nothing starts.
- A failing second run shows the early permanent exit.
- Two passing reruns with equal words give the only transient path.
- Equal pass flags with unequal words show that the held word, not just the flag, decides.
- A failing third run with a matching word shows that the third check outcome still counts.
- Withholding done in either run measures the timeout boundary to the exact cycle.
- A start pulsed in the middle of a sequence must leave the transient outcome unchanged.
- A final reset shows that the sticky flag clears.

// File: rtl/fvu_pkg.sv
package fvu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SECOND,
        ST_THIRD,
        ST_KEEP,
        ST_REPLACE
    } fvu_state_e;

endpackage

// File: rtl/fvu_watchdog.sv
module fvu_watchdog #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/fvu_word_hold.sv
module fvu_word_hold #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              match_o
);
    logic [WORD_W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (load_i) begin
            held_q <= word_i;
        end
    end

    assign match_o = (word_i == held_q);

endmodule

// File: rtl/fault_verdict_unit.sv
module fault_verdict_unit
    import fvu_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              first_ok_i,
    output logic              rerun_req_o,
    input  logic              rerun_done_i,
    input  logic              rerun_ok_i,
    input  logic [WORD_W-1:0] rerun_word_i,
    output logic              busy_o,
    output logic              transient_o,
    output logic              permanent_o,
    output logic              perm_latched_o
);
    fvu_state_e state_q, state_d;
    logic       in_run;
    logic       expired;
    logic       word_match;
    logic       load_word;
    logic       perm_flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && !first_ok_i) begin
                    state_d = ST_SECOND;
                end
            end
            ST_SECOND: begin
                if (rerun_done_i) begin
                    state_d = rerun_ok_i ? ST_THIRD : ST_REPLACE;
                end else if (expired) begin
                    state_d = ST_REPLACE;
                end
            end
            ST_THIRD: begin
                if (rerun_done_i) begin
                    state_d = (rerun_ok_i && word_match) ? ST_KEEP : ST_REPLACE;
                end else if (expired) begin
                    state_d = ST_REPLACE;
                end
            end
            ST_KEEP:    state_d = ST_IDLE;
            ST_REPLACE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_run      = (state_q == ST_SECOND) || (state_q == ST_THIRD);
        rerun_req_o = in_run;
        busy_o      = (state_q != ST_IDLE);
        transient_o = (state_q == ST_KEEP);
        permanent_o = (state_q == ST_REPLACE);
        load_word   = (state_q == ST_SECOND) && rerun_done_i && rerun_ok_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perm_flag_q <= 1'b0;
        end else if (state_q == ST_REPLACE) begin
            perm_flag_q <= 1'b1;
        end
    end

    assign perm_latched_o = perm_flag_q;

    fvu_watchdog #(
        .LIMIT (TIMEOUT_CYC)
    ) i_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (in_run),
        .clr_i     (state_d != state_q),
        .expired_o (expired)
    );

    fvu_word_hold #(
        .WORD_W (WORD_W)
    ) i_word_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_word),
        .word_i  (rerun_word_i),
        .match_o (word_match)
    );

endmodule

// File: rtl/fvu_checks.sv
module fvu_checks #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              first_ok_i,
    input logic              rerun_req_o,
    input logic              rerun_done_i,
    input logic              rerun_ok_i,
    input logic [WORD_W-1:0] rerun_word_i,
    input logic              busy_o,
    input logic              transient_o,
    input logic              permanent_o,
    input logic              perm_latched_o
);
    AST_PASS_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && first_ok_i) |=> !busy_o && !rerun_req_o); // R1

    AST_FAIL_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !first_ok_i) |=> rerun_req_o && busy_o); // R2

    AST_SECOND_FAIL_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        (rerun_req_o && rerun_done_i && !rerun_ok_i) |=> permanent_o); // R3

    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(transient_o && permanent_o)); // R8

    AST_KEEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        transient_o |=> !transient_o && !busy_o); // R8

    AST_REPLACE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        permanent_o |=> !permanent_o && !busy_o); // R8

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rerun_req_o); // R2

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        permanent_o |=> perm_latched_o); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        perm_latched_o |=> perm_latched_o); // R9

endmodule

bind fault_verdict_unit fvu_checks #(.WORD_W(WORD_W)) u_fvu_checks (.*);

// File: tb/test_fault_verdict_unit.sv
module test_fault_verdict_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int TMO        = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         first_ok_i = 1'b0;
    logic         rerun_req_o;
    logic         rerun_done_i = 1'b0;
    logic         rerun_ok_i = 1'b0;
    logic [W-1:0] rerun_word_i = '0;
    logic         busy_o;
    logic         transient_o;
    logic         permanent_o;
    logic         perm_latched_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fault_verdict_unit #(
        .WORD_W      (W),
        .TIMEOUT_CYC (TMO)
    ) i_fault_verdict_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .first_ok_i     (first_ok_i),
        .rerun_req_o    (rerun_req_o),
        .rerun_done_i   (rerun_done_i),
        .rerun_ok_i     (rerun_ok_i),
        .rerun_word_i   (rerun_word_i),
        .busy_o         (busy_o),
        .transient_o    (transient_o),
        .permanent_o    (permanent_o),
        .perm_latched_o (perm_latched_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start_seq(logic ok);
        @(negedge clk);
        start_i    = 1'b1;
        first_ok_i = ok;
        @(negedge clk);
        start_i    = 1'b0;
        first_ok_i = 1'b0;
    endtask

    task automatic serve(int delay, logic ok, logic [W-1:0] w);
        while (!rerun_req_o) @(negedge clk);
        repeat (delay) @(negedge clk);
        rerun_done_i = 1'b1;
        rerun_ok_i   = ok;
        rerun_word_i = w;
        @(negedge clk);
        rerun_done_i = 1'b0;
        rerun_ok_i   = 1'b0;
    endtask

    task automatic t_reset;
        check("R9 reset flag", perm_latched_o, 0);
        check("R2 reset req", rerun_req_o, 0);
        check("R8 reset busy", busy_o, 0);
    endtask

    task automatic t_first_pass;
        start_seq(1'b1);
        check("R1 busy", busy_o, 0);
        check("R1 req", rerun_req_o, 0);
        check("R1 verdicts", {transient_o, permanent_o}, 0);
    endtask

    task automatic t_transient;
        start_seq(1'b0);
        check("R2 req", rerun_req_o, 1);
        check("R2 busy", busy_o, 1);
        serve(2, 1'b1, 32'hCAFE_0001);
        check("R4 third req", rerun_req_o, 1);
        serve(1, 1'b1, 32'hCAFE_0001);
        check("R5 transient", transient_o, 1);
        check("R5 no perm", permanent_o, 0);
        @(negedge clk);
        check("R8 pulse end", transient_o, 0);
        check("R8 idle", busy_o, 0);
        check("R9 flag clear after transient", perm_latched_o, 0);
    endtask

    task automatic t_second_fail;
        start_seq(1'b0);
        serve(1, 1'b0, 32'h1234);
        check("R3 perm", permanent_o, 1);
        check("R3 no transient", transient_o, 0);
        @(negedge clk);
        check("R8 perm pulse end", permanent_o, 0);
        check("R9 flag set", perm_latched_o, 1);
    endtask

    task automatic t_mismatch;
        start_seq(1'b0);
        serve(0, 1'b1, 32'hAAAA_5555);
        serve(2, 1'b1, 32'hAAAA_5554);
        check("R6 mismatch perm", permanent_o, 1);
        @(negedge clk);
        check("R8 idle after mismatch", busy_o, 0);
    endtask

    task automatic t_third_fail;
        start_seq(1'b0);
        serve(1, 1'b1, 32'h77);
        serve(1, 1'b0, 32'h77);
        check("R6 third check fail", permanent_o, 1);
        check("R6 no transient", transient_o, 0);
        @(negedge clk);
    endtask

    task automatic t_timeout(bit in_third);
        start_seq(1'b0);
        if (in_third) begin
            serve(1, 1'b1, 32'h99);
        end
        repeat (TMO - 1) @(negedge clk);
        check(in_third ? "R7 third not yet" : "R7 second not yet", permanent_o, 0);
        check(in_third ? "R7 third req held" : "R7 second req held", rerun_req_o, 1);
        @(negedge clk);
        check(in_third ? "R7 third timeout" : "R7 second timeout", permanent_o, 1);
        @(negedge clk);
    endtask

    task automatic t_start_while_busy;
        start_seq(1'b0);
        serve(1, 1'b1, 32'h5A5A);
        start_i    = 1'b1;
        first_ok_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 req held under start", rerun_req_o, 1);
        serve(1, 1'b1, 32'h5A5A);
        check("R8 start ignored transient", transient_o, 1);
        @(negedge clk);
        check("R9 flag kept after transient", perm_latched_o, 1);
    endtask

    task automatic t_reset_clears;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset clears flag", perm_latched_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_pass();
        t_transient();
        t_second_fail();
        t_mismatch();
        t_third_fail();
        t_timeout(1'b0);
        t_timeout(1'b1);
        t_start_while_busy();
        t_reset_clears();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule